// File: doc/BRIEF.md
# Output Current Status Register with Alert Masking

This block keeps the latched output-current status byte of a power-management controller. Comparator events set four flags: overcurrent fault, overcurrent warning, undercurrent fault, and an undervoltage flag caused by the current limit. Once set, a flag stays set until it is cleared. The serial command decoder reads the byte and clears flags by writing 1 to them. Three other sources also clear flags: a global clear-faults strobe, an output-turn-on strobe, and a strobe from the voltage-status register.

Each flag has a disable input. A disabled flag is never recorded. A separate run-time alert mask decides which set flags drive the active-high alert request. That request feeds an open-drain alert driver outside the block. The overcurrent fault mask and the overcurrent warning mask can differ at run time, but they share one non-volatile default bit. A restore loads that bit into both masks. A store saves only the warning mask.

A small two-state machine handles the store. `MK_RUN` is the normal state. A store request in `MK_RUN` captures the warning mask and moves to `MK_SAVE`. `MK_SAVE` presents the saved bit for one cycle and always returns to `MK_RUN`. A store request that arrives in `MK_SAVE` is ignored.

Top module: `iout_status_reg`

## Requirements
- R1: After reset, the status byte, the mask byte, `alert_req` and `nv_store_valid` are all 0. Bits 3:0 of both read bytes are always 0.
- R2: Bit 7 (overcurrent fault), bit 5 (overcurrent warning) and bit 4 (undercurrent fault) are set one cycle after their event input is high. They stay set after the event goes away.
- R3: Bit 6 is set only when `vout_below_lv` and `iout_above_oc` are both high in the same cycle.
- R4: A status write clears each of bits 7, 5 and 4 whose data bit is 1. Data bits that are 0 have no effect. Written values at bit 6 and bits 3:0 are ignored.
- R5: Bit 6 is cleared only by `vout_uvf_clr`. Status writes, `clr_faults` and `out_on` leave it unchanged.
- R6: `clr_faults` or `out_on` clears bits 7, 5 and 4 one cycle later.
- R7: If a set event and a clear for the same flag arrive in the same cycle, the flag ends up set.
- R8: While a flag's disable input is high, that flag is not set. A flag that is already set is not cleared by its disable input.
- R9: `alert_req` is high exactly when some flag at bit 7, 6, 5 or 4 is set and its mask bit is 0. The mask never changes the status byte.
- R10: A mask write loads mask bits 7, 6, 5 and 4 independently from the same data bit positions. These bits read back at the same positions.
- R11: `nv_restore` loads mask bits 7 and 5 from `nv_bit` and leaves mask bits 6 and 4 unchanged. For bits 7 and 5, a restore overrides a mask write in the same cycle.
- R12: One cycle after a `nv_store` request in `MK_RUN`, `nv_store_valid` is high for exactly one cycle. During that cycle `nv_store_bit` equals mask bit 5 as it was at the time of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_oc_fault | input | 1 | Overcurrent fault comparator event |
| evt_oc_warn | input | 1 | Overcurrent warning comparator event |
| evt_uc_fault | input | 1 | Undercurrent fault comparator event |
| vout_below_lv | input | 1 | Output voltage below its low-voltage fault limit |
| iout_above_oc | input | 1 | Output current above its overcurrent fault limit |
| dis_oc_fault | input | 1 | Disable recording of bit 7 |
| dis_oc_warn | input | 1 | Disable recording of bit 5 |
| dis_uc_fault | input | 1 | Disable recording of bit 4 |
| dis_oc_lv | input | 1 | Disable recording of bit 6 |
| wr_stat_en | input | 1 | Status byte write strobe |
| wr_stat_data | input | 8 | Status write data; a 1 clears the flag at that position |
| stat_rd | output | 8 | Status byte |
| mask_wr_en | input | 1 | Mask byte write strobe |
| mask_wr_data | input | 8 | Mask write data |
| mask_rd | output | 8 | Mask byte |
| clr_faults | input | 1 | Global clear-faults strobe |
| out_on | input | 1 | Output turn-on strobe |
| vout_uvf_clr | input | 1 | Undervoltage fault cleared in the voltage status register |
| nv_restore | input | 1 | Restore the shared masks from non-volatile storage |
| nv_bit | input | 1 | Stored shared mask bit |
| nv_store | input | 1 | Request to save the shared mask bit |
| nv_store_valid | output | 1 | Saved bit is presented this cycle |
| nv_store_bit | output | 1 | Bit to save |
| alert_req | output | 1 | Alert request to the open-drain driver |

## Verification
The hardest case to reach is bit 6. It needs two inputs high in the same cycle, and it ignores every clear except the one from the voltage-status register. A stale bit 6 would therefore corrupt any later check that assumes a clean start. Before every pattern, the stimulus clears the register with `clr_faults` and `vout_uvf_clr` together. It then sweeps all 32 combinations of the five event inputs against all 16 disable patterns, which includes the cases where only one of the two bit-6 conditions is high. Directed sequences then collide each clear source with a set event in the same cycle, and collide a restore with a mask write.

// File: rtl/iout_stat_pkg.sv
package iout_stat_pkg;
    localparam int BYTE_W   = 8;
    localparam int NFLAG    = 4;
    localparam int FLAG_LSB = BYTE_W - NFLAG;
    // Flag index inside the upper nibble; the byte position is FLAG_LSB + index.
    localparam int IX_UCF   = 0;
    localparam int IX_OCW   = 1;
    localparam int IX_OCLV  = 2;
    localparam int IX_OCF   = 3;

    typedef enum logic [0:0] {
        MK_RUN  = 1'b0,
        MK_SAVE = 1'b1
    } mk_state_e;
endpackage

// File: rtl/iout_flag_cell.sv
module iout_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic blk,
    input  logic clr,
    output logic q
);
    logic set_ok;
    assign set_ok = set_evt & ~blk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= 1'b0;
        else if (set_ok) q <= 1'b1;
        else if (clr)    q <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt && !blk) |=> q); // R7
    AST_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr) |=> q); // R2
    AST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!q && blk) |=> !q); // R8
endmodule

// File: rtl/iout_mask_ctl.sv
module iout_mask_ctl
    import iout_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [NFLAG-1:0] wr_bits,
    input  logic             nv_restore,
    input  logic             nv_bit,
    input  logic             nv_store,
    output logic [NFLAG-1:0] mask_q,
    output logic             save_valid,
    output logic             save_bit
);
    mk_state_e state_q, state_d;
    logic      held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            if (wr_en) mask_q <= wr_bits;
            if (nv_restore) begin
                mask_q[IX_OCF] <= nv_bit;
                mask_q[IX_OCW] <= nv_bit;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MK_RUN:  if (nv_store) state_d = MK_SAVE;
            MK_SAVE: state_d = MK_RUN;
            default: state_d = MK_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MK_RUN;
            held_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == MK_RUN && nv_store) held_q <= mask_q[IX_OCW];
        end
    end

    always_comb begin
        save_valid = (state_q == MK_SAVE);
        save_bit   = save_valid ? held_q : 1'b0;
    end

    AST_RESTORE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        nv_restore |=> (mask_q[IX_OCF] == $past(nv_bit)) && (mask_q[IX_OCW] == $past(nv_bit))); // R11
    AST_SAVE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        save_valid |=> !save_valid); // R12
    AST_SAVE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!save_valid && nv_store) |=> (save_valid && save_bit == $past(mask_q[IX_OCW]))); // R12
endmodule

// File: rtl/iout_alert_gate.sv
module iout_alert_gate
    import iout_stat_pkg::*;
(
    input  logic [NFLAG-1:0] flags,
    input  logic [NFLAG-1:0] mask,
    output logic             alert
);
    logic [NFLAG-1:0] hit;
    for (genvar i = 0; i < NFLAG; i++) begin : g_hit
        assign hit[i] = flags[i] & ~mask[i];
    end
    assign alert = |hit;
endmodule

// File: rtl/iout_status_reg.sv
module iout_status_reg
    import iout_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_oc_fault,
    input  logic              evt_oc_warn,
    input  logic              evt_uc_fault,
    input  logic              vout_below_lv,
    input  logic              iout_above_oc,
    input  logic              dis_oc_fault,
    input  logic              dis_oc_warn,
    input  logic              dis_uc_fault,
    input  logic              dis_oc_lv,
    input  logic              wr_stat_en,
    input  logic [BYTE_W-1:0] wr_stat_data,
    output logic [BYTE_W-1:0] stat_rd,
    input  logic              mask_wr_en,
    input  logic [BYTE_W-1:0] mask_wr_data,
    output logic [BYTE_W-1:0] mask_rd,
    input  logic              clr_faults,
    input  logic              out_on,
    input  logic              vout_uvf_clr,
    input  logic              nv_restore,
    input  logic              nv_bit,
    input  logic              nv_store,
    output logic              nv_store_valid,
    output logic              nv_store_bit,
    output logic              alert_req
);
    logic [NFLAG-1:0] set_vec, blk_vec, clr_vec, flag_q, mask_q, w1c_bits;
    logic             unused_lo;

    assign unused_lo = ^{wr_stat_data[FLAG_LSB-1:0], mask_wr_data[FLAG_LSB-1:0]};
    assign w1c_bits  = wr_stat_data[FLAG_LSB +: NFLAG];

    always_comb begin
        set_vec[IX_UCF]  = evt_uc_fault;
        set_vec[IX_OCW]  = evt_oc_warn;
        set_vec[IX_OCLV] = vout_below_lv & iout_above_oc;
        set_vec[IX_OCF]  = evt_oc_fault;
        blk_vec[IX_UCF]  = dis_uc_fault;
        blk_vec[IX_OCW]  = dis_oc_warn;
        blk_vec[IX_OCLV] = dis_oc_lv;
        blk_vec[IX_OCF]  = dis_oc_fault;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        if (i == IX_OCLV) begin : g_foreign_clr
            assign clr_vec[i] = vout_uvf_clr;
        end else begin : g_local_clr
            assign clr_vec[i] = clr_faults | out_on | (wr_stat_en & w1c_bits[i]);
        end
        iout_flag_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (set_vec[i]),
            .blk     (blk_vec[i]),
            .clr     (clr_vec[i]),
            .q       (flag_q[i])
        );
    end

    iout_mask_ctl u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (mask_wr_en),
        .wr_bits    (mask_wr_data[FLAG_LSB +: NFLAG]),
        .nv_restore (nv_restore),
        .nv_bit     (nv_bit),
        .nv_store   (nv_store),
        .mask_q     (mask_q),
        .save_valid (nv_store_valid),
        .save_bit   (nv_store_bit)
    );

    iout_alert_gate u_alert (
        .flags (flag_q),
        .mask  (mask_q),
        .alert (alert_req)
    );

    assign stat_rd = {flag_q, {FLAG_LSB{1'b0}}};
    assign mask_rd = {mask_q, {FLAG_LSB{1'b0}}};

    AST_OCLV_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q[IX_OCLV] && !(vout_below_lv && iout_above_oc)) |=> !flag_q[IX_OCLV]); // R3
    AST_OCLV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[IX_OCLV] && !vout_uvf_clr) |=> flag_q[IX_OCLV]); // R5
    AST_GLOBAL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_faults || out_on) && !evt_oc_fault) |=> !flag_q[IX_OCF]); // R6
    AST_ALERT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(flag_q) == 0) |-> !alert_req); // R9
endmodule

// File: tb/sim_iout_status_reg.sv
module sim_iout_status_reg;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_oc_fault = 0, evt_oc_warn = 0, evt_uc_fault = 0;
    logic vout_below_lv = 0, iout_above_oc = 0;
    logic dis_oc_fault = 0, dis_oc_warn = 0, dis_uc_fault = 0, dis_oc_lv = 0;
    logic wr_stat_en = 0, mask_wr_en = 0;
    logic [7:0] wr_stat_data = 8'h00, mask_wr_data = 8'h00;
    logic clr_faults = 0, out_on = 0, vout_uvf_clr = 0;
    logic nv_restore = 0, nv_bit = 0, nv_store = 0;
    logic [7:0] stat_rd, mask_rd;
    logic nv_store_valid, nv_store_bit, alert_req;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    iout_status_reg u0 (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        evt_oc_fault = 0; evt_oc_warn = 0; evt_uc_fault = 0;
        vout_below_lv = 0; iout_above_oc = 0;
        dis_oc_fault = 0; dis_oc_warn = 0; dis_uc_fault = 0; dis_oc_lv = 0;
        wr_stat_en = 0; mask_wr_en = 0; clr_faults = 0; out_on = 0;
        vout_uvf_clr = 0; nv_restore = 0; nv_store = 0;
    endtask

    task automatic cyc();
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic clear_all();
        clr_faults = 1; vout_uvf_clr = 1;
        cyc();
    endtask

    // f bits: 0 undercurrent, 1 oc warning, 2 oc low-voltage, 3 oc fault
    task automatic set_flags(input logic [3:0] f);
        clear_all();
        evt_uc_fault = f[0]; evt_oc_warn = f[1];
        vout_below_lv = f[2]; iout_above_oc = f[2]; evt_oc_fault = f[3];
        cyc();
    endtask

    task automatic wr_mask(input logic [7:0] v);
        mask_wr_en = 1; mask_wr_data = v;
        cyc();
    endtask

    task automatic wr_stat(input logic [7:0] v);
        wr_stat_en = 1; wr_stat_data = v;
        cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0] ef;
        logic [7:0] a;
        idle();
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 stat", stat_rd, 8'h00);
        chk("R1 mask", mask_rd, 8'h00);
        chk("R1 alert", {7'd0, alert_req}, 8'h00);
        chk("R1 save", {7'd0, nv_store_valid}, 8'h00);
        @(negedge clk);
        rst_n = 1;
        #1;

        // R2 R3 R8 sweep: all event combos against all disable patterns
        for (int ev = 0; ev < 32; ev++) begin
            for (int ds = 0; ds < 16; ds++) begin
                clear_all();
                evt_oc_fault = ev[0]; evt_oc_warn = ev[1]; evt_uc_fault = ev[2];
                vout_below_lv = ev[3]; iout_above_oc = ev[4];
                dis_uc_fault = ds[0]; dis_oc_warn = ds[1]; dis_oc_lv = ds[2]; dis_oc_fault = ds[3];
                cyc();
                ef[0] = ev[2] & ~ds[0];
                ef[1] = ev[1] & ~ds[1];
                ef[2] = ev[3] & ev[4] & ~ds[2];
                ef[3] = ev[0] & ~ds[3];
                chk("R2/R3/R8 sweep", stat_rd, {ef, 4'h0});
            end
        end

        // R2 latched after events gone, several idle cycles
        set_flags(4'hF);
        cyc(); cyc();
        chk("R2 latched", stat_rd, 8'hF0);

        // R8 disable does not clear a set flag
        set_flags(4'hF);
        dis_oc_fault = 1; dis_oc_warn = 1; dis_uc_fault = 1; dis_oc_lv = 1;
        cyc();
        chk("R8 keep set", stat_rd, 8'hF0);

        // R4 write-1-to-clear
        set_flags(4'hF);
        wr_stat(8'h00); chk("R4 zero write", stat_rd, 8'hF0);
        wr_stat(8'h4F); chk("R4 bit6 and low ignored", stat_rd, 8'hF0);
        wr_stat(8'h80); chk("R4 clear bit7", stat_rd, 8'h70);
        wr_stat(8'h20); chk("R4 clear bit5", stat_rd, 8'h50);
        wr_stat(8'h10); chk("R4 clear bit4", stat_rd, 8'h40);
        // R5 only voltage-status clear removes bit 6
        wr_stat(8'hFF); chk("R5 write", stat_rd, 8'h40);
        clr_faults = 1; cyc(); chk("R5 clr_faults", stat_rd, 8'h40);
        out_on = 1; cyc(); chk("R5 out_on", stat_rd, 8'h40);
        vout_uvf_clr = 1; cyc(); chk("R5 uvf clr", stat_rd, 8'h00);

        // R6 global clears
        set_flags(4'hF);
        clr_faults = 1; cyc(); chk("R6 clr_faults", stat_rd, 8'h40);
        set_flags(4'hB);
        out_on = 1; cyc(); chk("R6 out_on", stat_rd, 8'h00);

        // R7 set beats clear
        clear_all();
        evt_oc_warn = 1; wr_stat_en = 1; wr_stat_data = 8'h20; cyc();
        chk("R7 w1c vs set", stat_rd, 8'h20);
        evt_oc_fault = 1; clr_faults = 1; cyc();
        chk("R7 clr_faults vs set", stat_rd, 8'h80);
        vout_below_lv = 1; iout_above_oc = 1; vout_uvf_clr = 1; cyc();
        chk("R7 uvf clr vs set", stat_rd, 8'hC0);
        evt_uc_fault = 1; out_on = 1; cyc();
        chk("R7 out_on vs set", stat_rd, 8'h50);

        // R9 R10 flags x masks sweep
        for (int f = 0; f < 16; f++) begin
            for (int m = 0; m < 16; m++) begin
                set_flags(f[3:0]);
                wr_mask({m[3:0], 4'h0});
                chk("R10 mask read", mask_rd, {m[3:0], 4'h0});
                chk("R9 status unaffected", stat_rd, {f[3:0], 4'h0});
                a = {7'd0, |(f[3:0] & ~m[3:0])};
                chk("R9 alert", {7'd0, alert_req}, a);
            end
        end

        // R11 restore
        wr_mask(8'hF0);
        nv_restore = 1; nv_bit = 0; cyc();
        chk("R11 restore 0", mask_rd, 8'h50);
        wr_mask(8'h00);
        nv_restore = 1; nv_bit = 1; cyc();
        chk("R11 restore 1", mask_rd, 8'hA0);
        nv_restore = 1; nv_bit = 0; mask_wr_en = 1; mask_wr_data = 8'hF0; cyc();
        chk("R11 restore beats write", mask_rd, 8'h50);
        wr_mask(8'h80);
        chk("R10 independent masks", mask_rd, 8'h80);

        // R12 store
        wr_mask(8'h20);
        nv_store = 1; cyc();
        chk("R12 valid", {7'd0, nv_store_valid}, 8'h01);
        chk("R12 bit1", {7'd0, nv_store_bit}, 8'h01);
        cyc();
        chk("R12 one cycle", {7'd0, nv_store_valid}, 8'h00);
        wr_mask(8'h80);
        nv_store = 1; cyc();
        chk("R12 bit0", {6'd0, nv_store_valid, nv_store_bit}, 8'h02);
        cyc();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule